// File: doc/BRIEF.md
# Boundary-Splitting Scatter-Gather Descriptor Builder

This block turns an ordered list of memory buffer segments, each given as a start address and a byte length, into the descriptor table that a bus-master DMA engine walks. No descriptor may straddle an aligned window of 2^WIN_W bytes (64 KiB by default). A segment that crosses one or more window edges is therefore cut into several pieces. Each piece is written to the table as one 16-byte entry of four 32-bit words.

A build begins with a `start` pulse. Segments then arrive over a valid/ready handshake, and the final one is flagged with `seg_last`. Each table word is written through a single write port. When the list is finished, the block goes back and rewrites the length word of the final entry so that it carries the end-of-list mark. A one-cycle `done` pulse then reports the number of entries. The table holds PAGE_BYTES/(4*ENTRY_BYTES) entries, which is 64 by default. If a build needs more entries than that, it is abandoned and the block reports zero entries with an overflow flag, so that the caller can move the data by programmed I/O instead.

Top module: `sg_desc_builder`

## Requirements
- R1: The length of each piece is 2^WIN_W minus the low WIN_W bits of the current address, or the bytes still left in the segment if that is smaller. With the default WIN_W of 16, a piece never crosses a 64 KiB boundary, and one piece may be exactly 0x10000 bytes long.
- R2: After each piece, the current address moves forward by the piece length and the bytes remaining drop by the same amount. The pieces of one segment therefore tile it contiguously, in ascending address order.
- R3: Entry i occupies table word addresses 4*i to 4*i+3. Those four words hold, in order: zero, the piece address, zero, and the piece length. Address and length words are byte-swapped (value bits 7:0 go to word bits 31:24, and so on).
- R4: After the last piece is written, the length word of the last entry is written once more with value bit 31 set. That bit is set on no other entry.
- R5: If a build would need more than the table capacity, no further entry is written and no end-of-list write happens. `done` then reports a count of 0 with `done_ovf` = 1. Any segments left up to `seg_last` are still accepted and discarded.
- R6: A build that needs exactly 64 entries succeeds and reports 64 with `done_ovf` = 0.
- R7: If the first segment has zero length, the build reports 0 entries with no overflow and makes no table write.
- R8: A zero-length segment ends the list. The segments after it, up to and including the one flagged `seg_last`, are accepted but produce no table write.
- R9: `done` is high for exactly one cycle per build. In that cycle, `done_count` and `done_ovf` hold the result.
- R10: After reset, `seg_ready`, `tbl_we` and `done` are low. `seg_ready` is high only while the block waits for a segment, and it is never high in a cycle that writes the table.
- R11: The entries of several segments follow one another in segment order, with no gap in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new build (taken while idle) |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W (32) | Segment length in bytes; 0 ends the list |
| seg_last | input | 1 | Final segment of this build |
| tbl_we | output | 1 | Table word write strobe |
| tbl_addr | output | log2(CAP)+2 (8) | Table word address |
| tbl_wdata | output | 32 | Table word data |
| done | output | 1 | Build finished (one cycle) |
| done_count | output | log2(CAP+1) (7) | Entry count, 0 on overflow |
| done_ovf | output | 1 | Table capacity exceeded |

## Verification
The assertions assume that every build ends with a segment flagged `seg_last`, and that `start` is given only while the block is idle. The window and address-advance checks also rely on segment lengths fitting in LEN_W without the address wrapping past 2^32. The stimulus respects all three conditions: each list it sends carries `seg_last` on its final entry only, `start` is pulsed only after the previous `done`, and every address plus length stays below 2^32. The sweep places segment start offsets on and just around window edges, and uses lengths that fall below, exactly on and beyond one window.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  localparam int SGD_WORD_W = 32;

  localparam logic [SGD_WORD_W-1:0] SGD_EOL_MARK = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EMIT,
    ST_EOL,
    ST_DRAIN,
    ST_DONE
  } sgd_state_e;

  function automatic logic [SGD_WORD_W-1:0] sgd_swap_bytes(input logic [SGD_WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/sgd_chunk_calc.sv
module sgd_chunk_calc #(
  parameter int LEN_W = 32,
  parameter int WIN_W = 16
) (
  input  logic [WIN_W-1:0] addr_lo,
  input  logic [LEN_W-1:0] remain,
  output logic [WIN_W:0]   chunk,
  output logic             last_piece
);

  localparam int PAD_W = LEN_W - WIN_W - 1;

  logic [WIN_W:0]   span;
  logic [LEN_W-1:0] span_ext;

  // bytes left before the next window edge
  assign span       = {1'b1, {WIN_W{1'b0}}} - {1'b0, addr_lo};
  assign span_ext   = {{PAD_W{1'b0}}, span};
  assign last_piece = (remain <= span_ext);
  assign chunk      = last_piece ? remain[WIN_W:0] : span;

endmodule

// File: rtl/sgd_entry_ctr.sv
module sgd_entry_ctr #(
  parameter int CAP   = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_cap,
  output logic             near_cap
);

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = clr ? '0 : count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end

  assign at_cap   = (count == CNT_W'(CAP));
  assign near_cap = (count == CNT_W'(CAP - 1));

endmodule

// File: rtl/sgd_word_fmt.sv
module sgd_word_fmt
  import sgd_pkg::*;
#(
  parameter int WIN_W      = 16,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [1:0]            sel,
  input  logic                  eol_phase,
  input  logic [SGD_WORD_W-1:0] addr,
  input  logic [WIN_W:0]        chunk,
  input  logic [WIN_W:0]        last_len,
  output logic [SGD_WORD_W-1:0] wdata
);

  localparam int LPAD_W = SGD_WORD_W - WIN_W - 1;

  logic [SGD_WORD_W-1:0] value;

  always_comb begin
    if (eol_phase) begin
      value = SGD_EOL_MARK | {{LPAD_W{1'b0}}, last_len};
    end else begin
      unique case (sel)
        2'd1:    value = addr;
        2'd3:    value = {{LPAD_W{1'b0}}, chunk};
        default: value = '0;
      endcase
    end
  end

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign wdata = sgd_swap_bytes(value);
    end else begin : g_plain
      assign wdata = value;
    end
  endgenerate

endmodule

// File: rtl/sg_desc_builder.sv
module sg_desc_builder
  import sgd_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int WIN_W       = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int ENTRY_BYTES = 16,
  parameter bit BIG_ENDIAN  = 1'b1,
  localparam int CAP        = PAGE_BYTES / (4 * ENTRY_BYTES),
  localparam int CNT_W      = $clog2(CAP + 1),
  localparam int IDX_W      = $clog2(CAP),
  localparam int TADDR_W    = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  seg_valid,
  output logic                  seg_ready,
  input  logic [SGD_WORD_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]      seg_len,
  input  logic                  seg_last,
  output logic                  tbl_we,
  output logic [TADDR_W-1:0]    tbl_addr,
  output logic [SGD_WORD_W-1:0] tbl_wdata,
  output logic                  done,
  output logic [CNT_W-1:0]      done_count,
  output logic                  done_ovf
);

  localparam int CPAD_W = SGD_WORD_W - WIN_W - 1;
  localparam int RPAD_W = LEN_W - WIN_W - 1;

  sgd_state_e            state_q, state_d;
  logic [SGD_WORD_W-1:0] cur_addr_q, cur_addr_d;
  logic [LEN_W-1:0]      remain_q, remain_d;
  logic                  seg_last_q, seg_last_d;
  logic                  seg_en;
  logic [1:0]            widx_q, widx_d;
  logic                  widx_en;
  logic [WIN_W:0]        last_len_q;
  logic                  llen_en;
  logic                  ovf_q, ovf_d;

  logic                  ctr_clr, ctr_inc;
  logic [CNT_W-1:0]      ctr_count;
  logic                  at_cap, near_cap;

  logic [WIN_W:0]        chunk;
  logic                  last_piece;
  logic                  emit_len_phase;
  logic                  eol_phase;
  sgd_state_e            fin_state;
  logic [IDX_W-1:0]      ent_idx;
  logic [1:0]            word_sel;

  sgd_chunk_calc #(
    .LEN_W (LEN_W),
    .WIN_W (WIN_W)
  ) u_calc (
    .addr_lo    (cur_addr_q[WIN_W-1:0]),
    .remain     (remain_q),
    .chunk      (chunk),
    .last_piece (last_piece)
  );

  sgd_entry_ctr #(
    .CAP   (CAP),
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctr_clr),
    .inc      (ctr_inc),
    .count    (ctr_count),
    .at_cap   (at_cap),
    .near_cap (near_cap)
  );

  assign emit_len_phase = (state_q == ST_EMIT) && (widx_q == 2'd3);
  assign eol_phase      = (state_q == ST_EOL);
  assign fin_state      = (ctr_count != '0) ? ST_EOL : ST_DONE;

  // next-state and datapath control
  always_comb begin
    state_d    = state_q;
    cur_addr_d = cur_addr_q;
    remain_d   = remain_q;
    seg_last_d = seg_last_q;
    seg_en     = 1'b0;
    widx_d     = widx_q;
    widx_en    = 1'b0;
    llen_en    = 1'b0;
    ovf_d      = ovf_q;
    ctr_clr    = 1'b0;
    ctr_inc    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FETCH;
          ctr_clr = 1'b1;
          ovf_d   = 1'b0;
        end
      end
      ST_FETCH: begin
        if (seg_valid) begin
          if (seg_len == '0) begin
            state_d = seg_last ? fin_state : ST_DRAIN;
          end else if (at_cap) begin
            ovf_d   = 1'b1;
            state_d = seg_last ? ST_DONE : ST_DRAIN;
          end else begin
            seg_en     = 1'b1;
            cur_addr_d = seg_addr;
            remain_d   = seg_len;
            seg_last_d = seg_last;
            widx_en    = 1'b1;
            widx_d     = 2'd0;
            state_d    = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        widx_en = 1'b1;
        widx_d  = widx_q + 2'd1;
        if (widx_q == 2'd3) begin
          ctr_inc    = 1'b1;
          seg_en     = 1'b1;
          llen_en    = 1'b1;
          cur_addr_d = cur_addr_q + {{CPAD_W{1'b0}}, chunk};
          remain_d   = remain_q - {{RPAD_W{1'b0}}, chunk};
          if (last_piece) begin
            state_d = seg_last_q ? ST_EOL : ST_FETCH;
          end else if (near_cap) begin
            ovf_d   = 1'b1;
            state_d = seg_last_q ? ST_DONE : ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (seg_valid && seg_last) begin
          state_d = ovf_q ? ST_DONE : fin_state;
        end
      end
      ST_EOL:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
      seg_last_q <= 1'b0;
      widx_q     <= 2'd0;
      last_len_q <= '0;
      ovf_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      if (seg_en) begin
        cur_addr_q <= cur_addr_d;
        remain_q   <= remain_d;
        seg_last_q <= seg_last_d;
      end
      if (widx_en) begin
        widx_q <= widx_d;
      end
      if (llen_en) begin
        last_len_q <= chunk;
      end
    end
  end

  // table write port
  assign ent_idx  = eol_phase ? (ctr_count[IDX_W-1:0] - IDX_W'(1)) : ctr_count[IDX_W-1:0];
  assign word_sel = eol_phase ? 2'd3 : widx_q;
  assign tbl_we   = (state_q == ST_EMIT) || eol_phase;
  assign tbl_addr = {ent_idx, word_sel};

  sgd_word_fmt #(
    .WIN_W      (WIN_W),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_fmt (
    .sel       (word_sel),
    .eol_phase (eol_phase),
    .addr      (cur_addr_q),
    .chunk     (chunk),
    .last_len  (last_len_q),
    .wdata     (tbl_wdata)
  );

  assign seg_ready  = (state_q == ST_FETCH) || (state_q == ST_DRAIN);
  assign done       = (state_q == ST_DONE);
  assign done_count = ovf_q ? '0 : ctr_count;
  assign done_ovf   = ovf_q;

endmodule

// File: rtl/sgd_checker.sv
module sgd_checker #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 7,
  parameter int CAP   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_ready,
  input logic             tbl_we,
  input logic             done,
  input logic [CNT_W-1:0] done_count,
  input logic             done_ovf,
  input logic             emit_len_phase,
  input logic [31:0]      cur_addr,
  input logic [WIN_W:0]   chunk
);

  localparam logic [WIN_W+1:0] WIN_BYTES = (WIN_W+2)'(1) << WIN_W;

  AST_CHUNK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    emit_len_phase |-> (chunk != '0) &&
      (({2'b00, cur_addr[WIN_W-1:0]} + {1'b0, chunk}) <= WIN_BYTES)); // R1

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_len_phase |=> cur_addr == ($past(cur_addr) + 32'($past(chunk)))); // R2

  AST_OVF_REPORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_ovf) |-> (done_count == '0)); // R5

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= CNT_W'(CAP))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_NO_WRITE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !seg_ready); // R10

endmodule

bind sg_desc_builder sgd_checker #(
  .WIN_W (WIN_W),
  .CNT_W (CNT_W),
  .CAP   (CAP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .seg_ready      (seg_ready),
  .tbl_we         (tbl_we),
  .done           (done),
  .done_count     (done_count),
  .done_ovf       (done_ovf),
  .emit_len_phase (emit_len_phase),
  .cur_addr       (cur_addr_q),
  .chunk          (chunk)
);

// File: tb/sim_sg_desc_builder.sv
module sim_sg_desc_builder;

  localparam int CAP = 64;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        seg_valid;
  logic        seg_ready;
  logic [31:0] seg_addr;
  logic [31:0] seg_len;
  logic        seg_last;
  logic        tbl_we;
  logic [7:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        done;
  logic [6:0]  done_count;
  logic        done_ovf;

  sg_desc_builder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .seg_valid  (seg_valid),
    .seg_ready  (seg_ready),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .seg_last   (seg_last),
    .tbl_we     (tbl_we),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata),
    .done       (done),
    .done_count (done_count),
    .done_ovf   (done_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests_run  = 0;
  int tests_fail = 0;
  bit finished   = 1'b0;

  // observed table and result, written only here
  logic [31:0] mem [256];
  int          mem_run [256];
  int          wr_cnt   = 0;
  int          done_seq = 0;
  int          run_id   = 0;
  logic [6:0]  got_cnt;
  logic        got_ovf;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tbl_we) begin
        mem[tbl_addr]     = tbl_wdata;
        mem_run[tbl_addr] = run_id;
        wr_cnt            = wr_cnt + 1;
      end
      if (done) begin
        got_cnt  = done_count;
        got_ovf  = done_ovf;
        done_seq = done_seq + 1;
      end
    end
  end

  // stimulus list
  logic [31:0] s_addr [8];
  logic [31:0] s_len  [8];
  int          nseg;

  // expected entries
  logic [31:0] e_addr [CAP];
  logic [31:0] e_len  [CAP];

  function automatic logic [31:0] bs(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_list(input string req);
    int          cnt;
    bit          ovf;
    bit          stop;
    logic [31:0] a;
    longint      r;
    longint      c;
    int          base_wr;
    int          base_done;
    int          exp_wr;
    bit          tbl_ok;
    int          bad_i;
    cnt  = 0;
    ovf  = 1'b0;
    stop = 1'b0;
    for (int i = 0; i < nseg; i++) begin
      if (!stop) begin
        if (s_len[i] == 0) begin
          stop = 1'b1;
        end else begin
          a = s_addr[i];
          r = longint'(s_len[i]);
          while (r > 0 && !stop) begin
            if (cnt == CAP) begin
              ovf  = 1'b1;
              stop = 1'b1;
            end else begin
              c = 65536 - longint'(a[15:0]);
              if (c > r) c = r;
              e_addr[cnt] = a;
              e_len[cnt]  = 32'(c);
              cnt++;
              a = a + 32'(c);
              r = r - c;
            end
          end
        end
      end
    end
    exp_wr = ovf ? 4 * CAP : (4 * cnt + ((cnt > 0) ? 1 : 0));

    run_id    = run_id + 1;
    base_wr   = wr_cnt;
    base_done = done_seq;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nseg; i++) begin
      seg_valid = 1'b1;
      seg_addr  = s_addr[i];
      seg_len   = s_len[i];
      seg_last  = (i == nseg - 1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
    end
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    while (done_seq == base_done) @(negedge clk);

    check(got_ovf == ovf, req, "overflow flag", 32'(got_ovf), 32'(ovf));
    check(got_cnt == (ovf ? 7'd0 : 7'(cnt)), req, "entry count",
          32'(got_cnt), ovf ? 32'd0 : 32'(cnt));
    check((wr_cnt - base_wr) == exp_wr, req, "table writes",
          32'(wr_cnt - base_wr), 32'(exp_wr));
    if (!ovf && cnt > 0) begin
      tbl_ok = 1'b1;
      bad_i  = 0;
      for (int i = 0; i < cnt; i++) begin
        if (tbl_ok) begin
          if (mem_run[4*i] != run_id || mem[4*i] != 32'd0 ||
              mem_run[4*i+1] != run_id || mem[4*i+1] != bs(e_addr[i]) ||
              mem_run[4*i+2] != run_id || mem[4*i+2] != 32'd0 ||
              mem_run[4*i+3] != run_id ||
              mem[4*i+3] != bs(e_len[i] | ((i == cnt - 1) ? 32'h8000_0000 : 32'd0))) begin
            tbl_ok = 1'b0;
            bad_i  = i;
          end
        end
      end
      // R3 word order/byte swap, R4 end mark, R1/R2 piece split
      check(tbl_ok, {req, " R1 R2 R3 R4"}, "table entry content",
            mem[4*bad_i+3], bs(e_len[bad_i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [5];
    logic [31:0] lens [5];
    rst_n     = 1'b0;
    start     = 1'b0;
    seg_valid = 1'b0;
    seg_addr  = '0;
    seg_len   = '0;
    seg_last  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!seg_ready && !tbl_we && !done, "R10", "idle outputs after reset",
          {29'd0, seg_ready, tbl_we, done}, 32'd0);

    // R1 R2 R3 R4 sweep of start offsets and lengths around window edges
    offs = '{32'h0, 32'h1, 32'h7FFF, 32'hFFF0, 32'hFFFF};
    lens = '{32'h1, 32'h10, 32'h10000, 32'h10001, 32'h2FFFF};
    for (int o = 0; o < 5; o++) begin
      for (int l = 0; l < 5; l++) begin
        nseg = 1;
        s_addr[0] = 32'h0003_0000 + offs[o];
        s_len[0]  = lens[l];
        run_list("R1");
      end
    end

    // R11 several segments in order
    nseg = 3;
    s_addr[0] = 32'h1000_0000; s_len[0] = 32'h200;
    s_addr[1] = 32'h2001_FF00; s_len[1] = 32'h300;
    s_addr[2] = 32'h3000_0040; s_len[2] = 32'h40;
    run_list("R11");

    // R7 empty list
    nseg = 1;
    s_addr[0] = 32'h4000_0000; s_len[0] = 32'h0;
    run_list("R7");

    // R7 zero first then more
    nseg = 3;
    s_addr[0] = 32'h4000_0000; s_len[0] = 32'h0;
    s_addr[1] = 32'h5000_0000; s_len[1] = 32'h100;
    s_addr[2] = 32'h6000_0000; s_len[2] = 32'h100;
    run_list("R7");

    // R8 zero length in the middle
    nseg = 4;
    s_addr[0] = 32'h0000_FFF0; s_len[0] = 32'h20;
    s_addr[1] = 32'h7000_0000; s_len[1] = 32'h0;
    s_addr[2] = 32'h7100_0000; s_len[2] = 32'h100;
    s_addr[3] = 32'h7200_0000; s_len[3] = 32'h100;
    run_list("R8");

    // R6 exactly full table
    nseg = 1;
    s_addr[0] = 32'h0100_0000; s_len[0] = 32'h0040_0000;
    run_list("R6");

    // R6 full table reached across two segments
    nseg = 2;
    s_addr[0] = 32'h0200_0000; s_len[0] = 32'h003F_0000;
    s_addr[1] = 32'h0300_8000; s_len[1] = 32'h8000;
    run_list("R6");

    // R5 one piece too many inside a segment
    nseg = 1;
    s_addr[0] = 32'h0100_0000; s_len[0] = 32'h0040_0001;
    run_list("R5");

    // R5 table full, next segment needs more, then drain
    nseg = 3;
    s_addr[0] = 32'h0100_0000; s_len[0] = 32'h0040_0000;
    s_addr[1] = 32'h0900_0000; s_len[1] = 32'h10;
    s_addr[2] = 32'h0A00_0000; s_len[2] = 32'h10;
    run_list("R5");

    // R9 builder reusable after overflow
    nseg = 1;
    s_addr[0] = 32'h0B00_FFFE; s_len[0] = 32'h4;
    run_list("R9");
    @(negedge clk);
    check(!done, "R9", "done cleared after pulse", 32'(done), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule